// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address stream for one burst of a synchronous DRAM read or write. A start strobe captures a start column, a three-bit length code and a one-bit ordering type. From the next cycle on, the block puts out one column address per clock, together with a valid flag and a flag that marks the final beat.

Two orderings are available. Sequential order counts upward and wraps inside the aligned block whose size is the burst length. Interleave order XORs the beat index into the low bits of the start column. A full-page mode runs through all 256 columns in ascending order, wrapping modulo 256, and keeps going until a stop strobe ends it.

A stop strobe can end any burst early. A new start strobe during a burst restarts the burst at once. A start that names an unsupported length/type combination issues no beats and pulses an error flag instead.

Top module: `sdram_colgen`

## Requirements
- R1: While reset is held and after its release with no start, `colValid`, `lastBeat` and `cfgErr` are 0.
- R2: A legal start sampled at clock edge N makes `colValid` 1 and `colAddr` equal the captured start column in the cycle after edge N.
- R3: When `burstType`=0 and the length code is 000, 001, 010 or 011, beat k has low bits (start+k) mod L, with L = 1, 2, 4 or 8. Address bits at and above log2(L) keep their start value (example: L=4, start low bits 1 gives 1,2,3,0).
- R4: When `burstType`=1, beat k has low bits (start XOR k) over log2(L) bits, and upper bits are unchanged (example: L=8, start 5 gives 5,4,7,6,1,0,3,2).
- R5: Length codes 000, 001, 010 and 011 issue exactly 1, 2, 4 and 8 beats. `lastBeat` is 1 only on the final beat, and `colValid` is 0 in the following cycle unless a start was sampled.
- R6: Code 111 with `burstType`=0 is full page: addresses run start, start+1, … modulo 256 without end, and `lastBeat` stays 0.
- R7: A stop sampled at an edge forces `colValid` to 0 in the next cycle, in any mode. A start sampled at the same edge outranks the stop.
- R8: Codes 100, 101 and 110, and code 111 with `burstType`=1, are illegal. A start carrying one of them issues no beat, ends any running burst, and sets `cfgErr` to 1 for exactly the one cycle after the edge.
- R9: A legal start sampled during a running burst restarts the sequence from the new start column in the next cycle, with the new length and type.
- R10: Changes on `startCol`, `lenCode` and `burstType` without a start strobe have no effect on a running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| startStb | input | 1 | Begin a burst with the present settings |
| stopStb | input | 1 | Terminate the running burst |
| startCol | input | COL_W (8) | Start column of the burst |
| lenCode | input | 3 | Burst length code |
| burstType | input | 1 | 0 sequential, 1 interleave |
| colAddr | output | COL_W (8) | Column address of the present beat |
| colValid | output | 1 | A beat is being issued this cycle |
| lastBeat | output | 1 | Present beat is the final one |
| cfgErr | output | 1 | One-cycle pulse after an illegal start |

## Verification
Every output here comes straight from registers that load on the edge that samples a strobe. The first beat, a cleared valid after a stop or final beat, and an error pulse are all due exactly one cycle after the sampling edge. The bench drives inputs on falling edges and advances its behavioural model on rising edges. It compares all four outputs with the model on each falling edge, so every result is judged in the cycle it is due. Full-page runs pass 256 beats to show the modulo wrap. Restart, stop and same-edge start-plus-stop are placed at chosen beats inside bursts.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture start settings, beat index to zero
    logic advance;  // step to the next beat
  } colCtl_t;

  localparam logic [2:0] LEN_FULL = 3'b111;

  // Legal settings: codes 0..3 with either type, full page with sequential only
  function automatic logic lenLegal(input logic [2:0] code, input logic ilv);
    return (code[2] == 1'b0) || (code == LEN_FULL && !ilv);
  endfunction

endpackage

// File: rtl/sdram_colgen_ctrl.sv
module sdram_colgen_ctrl
  import sdram_colgen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startStb,
  input  logic       stopStb,
  input  logic [2:0] lenCode,
  input  logic       burstType,
  input  logic       atLast,
  output colCtl_t    ctl,
  output logic       busy,
  output logic       cfgErr
);

  logic legal;
  logic busyNext;

  assign legal = lenLegal(lenCode, burstType);

  always_comb begin
    ctl.load    = startStb && legal;
    ctl.advance = busy && !startStb && !stopStb && !atLast;
  end

  always_comb begin
    if (startStb)            busyNext = legal;
    else if (stopStb)        busyNext = 1'b0;
    else if (busy && atLast) busyNext = 1'b0;
    else                     busyNext = busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cfgErr <= 1'b0;
    end else begin
      busy   <= busyNext;
      cfgErr <= startStb && !legal;
    end
  end

endmodule

// File: rtl/sdram_colgen_dp.sv
module sdram_colgen_dp
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  colCtl_t          ctl,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             burstType,
  output logic [COL_W-1:0] colAddr,
  output logic             atLast
);

  localparam int MAX_SHORT = 8;  // longest bounded burst

  logic [COL_W-1:0] baseReg, maskReg, beatCnt;
  logic             ilvReg, fullReg;
  logic [COL_W-1:0] newMask;
  logic [COL_W-1:0] offs;
  logic             newFull;

  assign newFull = (lenCode == LEN_FULL);

  // Mask of the address bits that move within the burst
  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    if (i < $clog2(MAX_SHORT)) begin : g_low
      assign newMask[i] = newFull || (i < int'(lenCode[1:0]));
    end else begin : g_high
      assign newMask[i] = newFull;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
      maskReg <= '0;
      beatCnt <= '0;
      ilvReg  <= 1'b0;
      fullReg <= 1'b0;
    end else if (ctl.load) begin
      baseReg <= startCol;
      maskReg <= newMask;
      beatCnt <= '0;
      ilvReg  <= burstType;
      fullReg <= newFull;
    end else if (ctl.advance) begin
      beatCnt <= beatCnt + 1'b1;
    end
  end

  assign offs    = ilvReg ? (baseReg ^ beatCnt) : (baseReg + beatCnt);
  assign colAddr = (baseReg & ~maskReg) | (offs & maskReg);
  assign atLast  = !fullReg && ((beatCnt & maskReg) == maskReg);

endmodule

// File: rtl/sdram_colgen.sv
module sdram_colgen
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic             stopStb,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             burstType,
  output logic [COL_W-1:0] colAddr,
  output logic             colValid,
  output logic             lastBeat,
  output logic             cfgErr
);

  colCtl_t ctl;
  logic    busy;
  logic    atLast;

  sdram_colgen_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startStb  (startStb),
    .stopStb   (stopStb),
    .lenCode   (lenCode),
    .burstType (burstType),
    .atLast    (atLast),
    .ctl       (ctl),
    .busy      (busy),
    .cfgErr    (cfgErr)
  );

  sdram_colgen_dp #(.COL_W(COL_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .startCol  (startCol),
    .lenCode   (lenCode),
    .burstType (burstType),
    .colAddr   (colAddr),
    .atLast    (atLast)
  );

  assign colValid = busy;
  assign lastBeat = busy && atLast;

endmodule

// File: rtl/sdram_colgen_chk.sv
module sdram_colgen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             startStb,
  input logic             stopStb,
  input logic [COL_W-1:0] startCol,
  input logic [2:0]       lenCode,
  input logic             burstType,
  input logic [COL_W-1:0] colAddr,
  input logic             colValid,
  input logic             lastBeat,
  input logic             cfgErr
);

  logic fullSeen;

  always_ff @(posedge clk) begin
    if (!rstN)         fullSeen <= 1'b0;
    else if (startStb) fullSeen <= (lenCode == 3'b111);
  end

  // R1 / R5: final-beat flag only on a valid beat
  p_last_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> colValid);

  // R5: after the final beat the burst ends unless restarted
  p_end_after_last_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !startStb) |=> !colValid);

  // R7: stop ends the burst next cycle
  p_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stopStb && !startStb) |=> !colValid);

  // R2 / R9: legal start gives first beat at the start column
  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && (!lenCode[2] || (lenCode == 3'b111 && !burstType)))
      |=> (colValid && colAddr == $past(startCol)));

  // R8: illegal start gives an error pulse and no beat
  p_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> (!colValid && $past(startStb)));

  // R3 / R4: upper bits fixed within a bounded burst
  p_upper_fixed_r3: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && $past(colValid) && !$past(startStb) && !fullSeen)
      |-> colAddr[COL_W-1:3] == $past(colAddr[COL_W-1:3]));

  // R6: full page never flags a final beat
  p_full_no_last_r6: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && fullSeen) |-> !lastBeat);

endmodule

bind sdram_colgen sdram_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startStb  (startStb),
  .stopStb   (stopStb),
  .startCol  (startCol),
  .lenCode   (lenCode),
  .burstType (burstType),
  .colAddr   (colAddr),
  .colValid  (colValid),
  .lastBeat  (lastBeat),
  .cfgErr    (cfgErr)
);

// File: tb/sdram_colgen_tb.sv
`timescale 1ns/1ps
module sdram_colgen_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startStb = 1'b0;
  logic       stopStb = 1'b0;
  logic [7:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic       burstType = 1'b0;
  logic [7:0] colAddr;
  logic       colValid, lastBeat, cfgErr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string curReq = "R1";

  // behavioural model state
  int mAct = 0, mK = 0, mS = 0, mBl = 1, mIlv = 0, mFull = 0, mErr = 0;

  always #4 clk = ~clk;

  sdram_colgen u_dut (
    .clk(clk), .rstN(rstN), .startStb(startStb), .stopStb(stopStb),
    .startCol(startCol), .lenCode(lenCode), .burstType(burstType),
    .colAddr(colAddr), .colValid(colValid), .lastBeat(lastBeat), .cfgErr(cfgErr)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int expAddr();
    int base, off, eoff;
    base = mS - (mS % mBl);
    off  = mS % mBl;
    eoff = mIlv != 0 ? (off ^ mK) : ((off + mK) % mBl);
    return base + eoff;
  endfunction

  // model advances on each rising edge from the inputs held since the falling edge
  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mAct = 0; mErr = 0;
    end else if (startStb) begin
      if (lenCode < 4 || (lenCode == 7 && !burstType)) begin
        mAct = 1; mK = 0; mS = startCol; mIlv = burstType;
        mFull = (lenCode == 7);
        mBl = mFull != 0 ? 256 : (1 << lenCode);
        mErr = 0;
      end else begin
        mAct = 0; mErr = 1;
      end
    end else begin
      mErr = 0;
      if (stopStb) mAct = 0;
      else if (mAct != 0) begin
        if (mFull == 0 && mK == mBl - 1) mAct = 0;
        else mK = (mK + 1) % mBl;
      end
    end
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rstN) begin
      check(curReq, "colValid", int'(colValid), mAct);
      check(curReq, "cfgErr", int'(cfgErr), mErr);
      check(curReq, "lastBeat", int'(lastBeat),
            (mAct != 0 && mFull == 0 && mK == mBl - 1) ? 1 : 0);
      if (mAct != 0) check(curReq, "colAddr", int'(colAddr), expAddr());
    end
  end

  task automatic go(input int col, input int len, input bit ilv);
    @(negedge clk);
    startStb = 1'b1; startCol = 8'(col); lenCode = 3'(len); burstType = ilv;
    @(negedge clk);
    startStb = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stopNow();
    @(negedge clk); stopStb = 1'b1;
    @(negedge clk); stopStb = 1'b0;
  endtask

  // captured beats of the interleave example
  int seq[$];
  int ref8[8] = '{5, 4, 7, 6, 1, 0, 3, 2};

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "colValid in reset", int'(colValid), 0);
    check("R1", "cfgErr in reset", int'(cfgErr), 0);
    rstN = 1'b1;
    idle(3);

    // R2 R3 R5: sequential lengths
    curReq = "R2"; go(8'h2A, 0, 0); idle(2);
    curReq = "R3"; go(8'h13, 1, 0); idle(3);
    go(8'h41, 2, 0); idle(5);
    curReq = "R5"; go(8'h7D, 3, 0); idle(9);

    // R4: interleave lengths, and the 5,4,7,6,1,0,3,2 example
    curReq = "R4"; go(8'h35, 1, 1); idle(3);
    go(8'h36, 2, 1); idle(5);
    go(8'hC5, 3, 1);
    for (int i = 0; i < 8; i++) begin
      seq.push_back(int'(colAddr) & 7);
      @(negedge clk);
    end
    for (int i = 0; i < 8; i++) check("R4", "interleave beat", seq[i], ref8[i]);
    idle(2);

    // R10: input changes without a strobe are ignored
    curReq = "R10";
    go(8'h5A, 3, 0);
    startCol = 8'hFF; lenCode = 3'd0; burstType = 1'b1;
    idle(10);

    // R6 then R7: full page wrap, then stop
    curReq = "R6"; go(8'hFC, 7, 0); idle(300);
    curReq = "R7"; stopNow(); idle(3);
    go(8'h20, 3, 0); idle(3); stopNow(); idle(3);
    // start and stop on the same edge: start wins
    go(8'h60, 2, 1); idle(1);
    @(negedge clk); startStb = 1'b1; stopStb = 1'b1; startCol = 8'h91; lenCode = 3'd2; burstType = 1'b0;
    @(negedge clk); startStb = 1'b0; stopStb = 1'b0;
    idle(6);

    // R9: restart mid burst, back-to-back on final beat
    curReq = "R9";
    go(8'h18, 3, 0); idle(2);
    go(8'hE3, 2, 1); idle(2);
    go(8'h0B, 1, 0);
    go(8'h44, 0, 0); idle(4);

    // R8: illegal settings, including one that cuts a running burst
    curReq = "R8";
    go(8'h10, 4, 0); idle(2);
    go(8'h10, 5, 1); idle(2);
    go(8'h10, 6, 0); idle(2);
    go(8'h33, 7, 1); idle(2);
    go(8'h70, 3, 0); idle(2);
    go(8'h70, 5, 0); idle(2);
    go(8'h70, 4, 0); go(8'h71, 6, 0); idle(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule